// File: doc/BRIEF.md
# Interrupt Status Controller with Read-Clear

This block gathers one-cycle event pulses from up to sixteen sources into a sticky status register. Each bit stays set until the host clears it. The status register is masked by an enable register, and together they drive an active-low interrupt request. A host reaches the block through a four-wire serial slave port: chip select, serial clock, data in and data out. Over this port it can write and read the enable register, read the flags without changing them, or read the flags and clear them in one transaction. The read-and-clear transaction is how the host acknowledges interrupts.

Events can keep arriving while a read-and-clear transfer is under way. They are diverted into a separate pending register and are never lost. For the whole data phase of that transfer the request line is forced inactive. When chip select is released, the pending events become the new status contents, and the request is raised again if any of them are enabled. Chip select, serial clock and data in are each brought into the system clock through a two-flop synchronizer. Data in is sampled on the serial clock's falling edge, and data out changes on its rising edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, `irq_no` is 1, `sdo_o` is 0, and both the status and the enable register read as 0x0000.
- R2: An event pulse on `event_i[k]` sets status bit k whatever the value of enable bit k. A disabled bit never pulls `irq_no` low.
- R3: If any status bit is 1 and its enable bit is also 1, `irq_no` is 0. Outside a read-and-clear transfer, `irq_no` falls in the first clock cycle after the edge that samples an enabled event.
- R4: A write frame is a command byte with bit 7 = 1, bit 6 = 0 and the address in bits 5:0, followed by 16 data bits, MSB first. A write to address 0x0A loads the enable register once the 24th falling edge has been sampled. Writes to any other address change nothing.
- R5: A read frame is a command byte with bit 7 = 0, bit 6 = 0 and the address in bits 5:0. It is followed by 16 data bits on `sdo_o`, MSB first. Each bit changes on a rising edge and is sampled by the host on the following falling edge. A read of an unused address returns 0x0000.
- R6: A read of address 0x0B returns the status flags. It leaves the flags and `irq_no` unchanged.
- R7: A read of address 0x0C returns the status flags as they stood when the command byte completed. Once chip select is released after all 24 falling edges, the flags are cleared and `irq_no` returns to 1 unless new enabled events arrived in the meantime.
- R8: From the end of the command byte of a 0x0C read until chip select is released, `irq_no` stays at 1.
- R9: Events that arrive during a 0x0C transfer are left out of the returned word. They form the status contents after the transfer, and `irq_no` falls again afterwards if any of them is enabled.
- R10: If chip select is released before the 24th falling edge of a 0x0C read, no flag is cleared, and any pending events are added to the existing flags.
- R11: An event in the same cycle as the 0x0C snapshot is kept in the pending register and is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| event_i | input | NUM_SRC | One-cycle event pulses, one per source |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from host, idles low |
| sdi_i | input | 1 | Serial data from host, sampled on falling edge |
| sdo_o | output | 1 | Serial data to host, changes on rising edge |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
An event reaches `irq_no` in the first clock cycle after it is sampled. The bench drives each pulse at a falling system-clock edge and checks the request line at the next falling edge. Every serial edge is seen in the system domain about three clocks late: two synchronizer flops plus the edge detector. The host model therefore holds each serial clock phase for six clocks and samples `sdo_o` at the end of each high phase, by which time the rising-edge update has landed. After chip select rises, the bench waits ten clocks before it looks at the request line or starts the next frame. By then the clear or the merge of pending events is complete. The hold check runs in the middle of the data phase, a few bits after an enabled event has been injected.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 6'h0A;
  localparam logic [ADDR_W-1:0] ADDR_PEEK   = 6'h0B;
  localparam logic [ADDR_W-1:0] ADDR_ACK    = 6'h0C;

  typedef struct packed {
    logic              wr;
    logic              rsvd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_serial_port.sv
module irq_serial_port
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output cmd_t              cmd_next_o,
  output logic              cmd_valid_o,
  output cmd_t              cmd_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              end_o,
  output logic              full_o,
  output logic              sdo_o
);
  localparam int FRAME = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] in_sr, out_sr;
  cmd_t              cmd_q;
  logic              sdo_q;
  logic              fall, rise;

  assign fall = sclk_d & ~sclk_s_i & ~cs_n_s_i;
  assign rise = ~sclk_d & sclk_s_i & ~cs_n_s_i;

  assign cmd_next_o  = cmd_t'({in_sr[CMD_W-2:0], sdi_s_i});
  assign cmd_valid_o = fall && (cnt_q == CNT_W'(CMD_W - 1));
  assign wr_valid_o  = fall && (cnt_q == CNT_W'(FRAME - 1)) && cmd_q.wr;
  assign wr_data_o   = {in_sr[DATA_W-2:0], sdi_s_i};
  assign end_o       = ~cs_d & cs_n_s_i;
  assign full_o      = (cnt_q == CNT_W'(FRAME));
  assign cmd_o       = cmd_q;
  assign sdo_o       = sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      cnt_q  <= '0;
      in_sr  <= '0;
      out_sr <= '0;
      cmd_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s_i;
      cs_d   <= cs_n_s_i;
      if (cs_n_s_i) begin
        cnt_q <= '0;
        sdo_q <= 1'b0;
      end else begin
        if (fall && cnt_q != CNT_W'(FRAME)) begin
          cnt_q <= cnt_q + 1'b1;
          in_sr <= {in_sr[DATA_W-2:0], sdi_s_i};
          if (cmd_valid_o) begin
            cmd_q  <= cmd_next_o;
            out_sr <= rd_data_i;   // snapshot at end of command byte
          end
        end
        if (rise && cnt_q >= CNT_W'(CMD_W)) begin
          sdo_q  <= out_sr[DATA_W-1];
          out_sr <= {out_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic         ack_start_i,
  input  logic         xfer_end_i,
  input  logic         xfer_full_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o,
  output logic         hold_o,
  output logic         irq_no
);
  logic [N-1:0] status_q, pend_q, en_q;
  logic         hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      pend_q   <= '0;
      en_q     <= '0;
      hold_q   <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      if (ack_start_i) begin
        hold_q <= 1'b1;
        pend_q <= event_i;          // coincident event survives the clear
      end else if (hold_q) begin
        if (xfer_end_i) begin
          hold_q   <= 1'b0;
          pend_q   <= '0;
          status_q <= xfer_full_i ? (pend_q | event_i)
                                  : (status_q | pend_q | event_i);
        end else begin
          pend_q <= pend_q | event_i;
        end
      end else begin
        status_q <= status_q | event_i;
      end
    end
  end

  assign status_o = status_q;
  assign pend_o   = pend_q;
  assign en_o     = en_q;
  assign hold_o   = hold_q;
  assign irq_no   = hold_q | ~(|(status_q & en_q));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               cs_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               irq_no
);
  logic               cs_s, sclk_s, sdi_s;
  cmd_t               cmd_next, cmd_q;
  logic               cmd_valid, wr_valid, xfer_end, xfer_full;
  logic [NUM_SRC-1:0] wr_data, rd_data;
  logic [NUM_SRC-1:0] status_q, pend_q, en_q;
  logic               hold_q, ack_start, en_we;

  irq_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  irq_serial_port #(.DATA_W(NUM_SRC)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_s_i   (cs_s),
    .sclk_s_i   (sclk_s),
    .sdi_s_i    (sdi_s),
    .rd_data_i  (rd_data),
    .cmd_next_o (cmd_next),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd_q),
    .wr_valid_o (wr_valid),
    .wr_data_o  (wr_data),
    .end_o      (xfer_end),
    .full_o     (xfer_full),
    .sdo_o      (sdo_o)
  );

  always_comb begin
    rd_data = '0;
    if (!cmd_next.wr && !cmd_next.rsvd) begin
      unique case (cmd_next.addr)
        ADDR_ENABLE:        rd_data = en_q;
        ADDR_PEEK, ADDR_ACK: rd_data = status_q;
        default:            rd_data = '0;
      endcase
    end
  end

  assign ack_start = cmd_valid && !cmd_next.wr && !cmd_next.rsvd && (cmd_next.addr == ADDR_ACK);
  assign en_we     = wr_valid && !cmd_q.rsvd && (cmd_q.addr == ADDR_ENABLE);

  irq_flag_core #(.N(NUM_SRC)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .en_we_i    (en_we),
    .en_wdata_i (wr_data),
    .ack_start_i(ack_start),
    .xfer_end_i (xfer_end),
    .xfer_full_i(xfer_full),
    .status_o   (status_q),
    .pend_o     (pend_q),
    .en_o       (en_q),
    .hold_o     (hold_q),
    .irq_no     (irq_no)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] event_i,
  input logic         irq_no,
  input logic [N-1:0] status_q,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] en_q,
  input logic         hold_q,
  input logic         ack_start,
  input logic         xfer_end,
  input logic         xfer_full
);
  a_r2_event_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> (((status_q | pend_q) & $past(event_i)) == $past(event_i)));

  a_r3_enabled_event_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !ack_start && |(event_i & en_q)) |=> (!irq_no || en_q != $past(en_q)));

  a_r8_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> irq_no);

  a_r7_clear_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && xfer_end && xfer_full) |=> ((status_q & ~$past(pend_q | event_i)) == '0));

  a_r10_abort_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && xfer_end && !xfer_full) |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r11_coincident_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start && |event_i) |=> ((pend_q & $past(event_i)) == $past(event_i)));

  a_r9_pending_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_q |-> (pend_q == '0));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.N(NUM_SRC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .event_i  (event_i),
  .irq_no   (irq_no),
  .status_q (status_q),
  .pend_q   (pend_q),
  .en_q     (en_q),
  .hold_q   (hold_q),
  .ack_start(ack_start),
  .xfer_end (xfer_end),
  .xfer_full(xfer_full)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev = '0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, irq_n;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$], got_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  irq_status_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .cs_ni(cs_n),
    .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .irq_no(irq_n)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk) ev = v;
    @(negedge clk) ev = '0;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [15:0] wd, input int nbits,
                      input logic [15:0] inj, input bit chk_hold, output logic [15:0] rd);
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 8) ? cmd[7-i] : wd[23-i];
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i >= 8) rd[23-i] = sdo;
      sclk = 1'b0;
      if (i == 12 && inj != '0) begin
        ev = inj;
        @(negedge clk) ev = '0;
        repeat (H-1) @(negedge clk);
      end else begin
        repeat (H) @(negedge clk);
      end
      if (chk_hold && i == 16) check(irq_n == 1'b1, "R8 irq during ack", {15'd0, irq_n}, 16'h0001);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [5:0] addr, input logic [15:0] exp, input string tag,
                        input logic [15:0] inj, input bit chk_hold);
    logic [15:0] r;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer({2'b00, addr}, 16'h0000, 24, inj, chk_hold, r);
    got_q.push_back(r);
  endtask

  task automatic wr_reg(input logic [5:0] addr, input logic [15:0] d);
    logic [15:0] r;
    xfer({2'b10, addr}, d, 24, 16'h0000, 1'b0, r);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (got_q.size() > 0);
      begin
        logic [15:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g === e, t, g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] r;
    repeat (4) @(negedge clk);
    check(irq_n == 1'b1 && sdo == 1'b0, "R1 reset outputs", {14'd0, irq_n, sdo}, 16'h0002);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(6'h0B, 16'h0000, "R1 status after reset", '0, 0);
    rd_reg(6'h0A, 16'h0000, "R1 enable after reset", '0, 0);

    pulse(16'h0008);
    check(irq_n == 1'b1, "R2 disabled event no irq", {15'd0, irq_n}, 16'h0001);
    rd_reg(6'h0B, 16'h0008, "R2 flag set while disabled", '0, 0);

    wr_reg(6'h0A, 16'h00F0);
    rd_reg(6'h0A, 16'h00F0, "R4 enable readback", '0, 0);
    wr_reg(6'h07, 16'hFFFF);
    rd_reg(6'h0A, 16'h00F0, "R4 write other address ignored", '0, 0);
    check(irq_n == 1'b1, "R3 no enabled flag", {15'd0, irq_n}, 16'h0001);

    pulse(16'h0020);
    check(irq_n == 1'b0, "R3 enabled event lowers irq", {15'd0, irq_n}, 16'h0000);
    rd_reg(6'h0B, 16'h0028, "R6 peek returns flags", '0, 0);
    check(irq_n == 1'b0, "R6 peek leaves irq", {15'd0, irq_n}, 16'h0000);
    rd_reg(6'h0B, 16'h0028, "R6 peek did not clear", '0, 0);

    rd_reg(6'h05, 16'h0000, "R5 unused address", '0, 0);

    rd_reg(6'h0C, 16'h0028, "R9 ack returns snapshot only", 16'h0040, 1);
    check(irq_n == 1'b0, "R9 irq low again after ack", {15'd0, irq_n}, 16'h0000);
    rd_reg(6'h0B, 16'h0040, "R9 event kept after clear", '0, 0);

    rd_reg(6'h0C, 16'h0040, "R7 ack returns flags", '0, 0);
    check(irq_n == 1'b1, "R7 irq high after ack", {15'd0, irq_n}, 16'h0001);
    rd_reg(6'h0B, 16'h0000, "R7 flags cleared", '0, 0);

    pulse(16'h0080);
    xfer(8'h0C, 16'h0000, 12, 16'h0000, 1'b0, r);
    check(irq_n == 1'b0, "R10 abort keeps irq", {15'd0, irq_n}, 16'h0000);
    rd_reg(6'h0B, 16'h0080, "R10 abort keeps flags", '0, 0);

    rd_reg(6'h0C, 16'h0080, "R9 ack with disabled event", 16'h0002, 0);
    check(irq_n == 1'b1, "R9 disabled pending no irq", {15'd0, irq_n}, 16'h0001);
    rd_reg(6'h0B, 16'h0002, "R9 disabled pending kept", '0, 0);

    wait (got_q.size() == 0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule